// File: doc/BRIEF.md
# CAN Message FIFO Window Pair

This block buffers CAN frames between a CPU and a CAN protocol engine. It holds two small message queues, one for frames leaving the node and one for frames arriving. The CPU never addresses queue slots directly. It sees one fixed transmit window and one fixed receive window, and it moves each queue forward by writing a magic value to a pointer register.

To send a frame, the CPU fills the transmit window with an ID word, a DLC and data. It then writes 0xFF to the transmit pointer register, which appends the staged frame to the queue. The protocol engine takes frames from a valid/ready port. `tx_valid` stays high while an enabled transmit queue holds a frame. The frame on `tx_id`/`tx_dlc`/`tx_data` stays stable until `tx_ready` is seen high at a clock edge, and that edge removes it.

On the receive side, the engine offers frames with `rx_valid`. `rx_ready` is simply the receive enable, so a disabled queue back-pressures the engine. An enabled queue takes every offered frame. If the queue is full, the frame is lost and `rx_overrun` pulses. The CPU reads the oldest frame through the receive window and releases it with 0xFF to the receive pointer register. Two write-zero-to-clear event flags and their enables drive one interrupt line.

Top module: `can_fifo_window`

## Requirements
- R1: After reset, both queues are disabled and empty. The transmit control register reads 0 and the receive control register reads 0x80. Status, enables, `irq`, `tx_valid`, `rx_ready` and `rx_overrun` are all 0.
- R2: The transmit window is written at register 0 (ID word), 1 (DLC bits 3:0), 2 (data bytes 0–3) and 3 (data bytes 4–7), with byte 0 in bits 7:0. In the ID word, bit 31 marks an extended ID, bit 30 marks a remote request, a standard ID sits in bits 28:18 and an extended ID in bits 28:0. Writing exactly 0xFF to register 9 appends the staged frame unchanged, with data byte n in `tx_data` bits 8n+7:8n. Any other value written to register 9 is ignored.
- R3: In transmit control register 8, bit 0 is the enable and bits 3:1 give the number of committed frames not yet taken. Frames leave in commit order.
- R4: A commit is ignored while 4 frames are unsent or while the transmit queue is disabled.
- R5: A frame whose ID word has bit 30 set carries all-zero data on both the transmit port and the receive window, whatever data was supplied.
- R6: `tx_valid` is high exactly when the transmit queue is enabled and not empty. The presented frame holds stable until a clock edge with `tx_ready` high removes it.
- R7: In receive control register 10, bit 0 is the enable, and `rx_ready` follows it. Bit 7 reads 1 while the receive queue is empty. Registers 4–7 show the oldest received frame, laid out like registers 0–3.
- R8: Writing 0xFF to register 11 releases the oldest received frame. Any other value, or a release while the queue is empty, has no effect.
- R9: A frame offered while the enabled receive queue holds 4 frames is dropped. `rx_overrun` is high in that same cycle.
- R10: Status register 12 has bit 3 set on every transmit pop and bit 4 set on every stored receive frame. A write clears each flag whose bit is written 0 and keeps each flag whose bit is written 1.
- R11: Enable register 13 uses bit 3 for the transmit flag and bit 4 for the receive flag. `irq` is high exactly when some flag and its enable are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wr_en | input | 1 | CPU register write strobe |
| cpu_addr | input | 4 | CPU register index |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | CPU read data for `cpu_addr` (combinational) |
| tx_valid | output | 1 | Transmit frame available |
| tx_ready | input | 1 | Protocol engine takes the transmit frame |
| tx_id | output | 32 | Transmit frame ID word |
| tx_dlc | output | 4 | Transmit frame DLC |
| tx_data | output | 64 | Transmit frame data, byte 0 in bits 7:0 |
| rx_valid | input | 1 | Received frame offered |
| rx_ready | output | 1 | Receive queue accepts frames (enable) |
| rx_id | input | 32 | Received frame ID word |
| rx_dlc | input | 4 | Received frame DLC |
| rx_data | input | 64 | Received frame data, byte 0 in bits 7:0 |
| rx_overrun | output | 1 | Offered frame dropped on a full queue |
| irq | output | 1 | Interrupt request |

## Verification
A wrong read or write pointer shows up at once. The first frame after the fault appears on the transmit port or in the receive window with the wrong ID, so draining several tagged frames in order exposes it within one frame. A count that drifts shows up as a wrong unsent field, or an empty bit that disagrees with the window, on the next register read. It also shows up as a fifth commit or push that is accepted when it should be refused. Flag errors reach `irq` in the cycle after the event or the clearing write.

// File: rtl/cfw_pkg.sv
package cfw_pkg;
  localparam int ID_W    = 32;
  localparam int DLC_W   = 4;
  localparam int DATA_W  = 64;
  localparam int RTR_BIT = 30;
  localparam int TXF_BIT = 3;
  localparam int RXF_BIT = 4;
  localparam logic [7:0] PTR_MAGIC = 8'hFF;

  localparam logic [3:0] A_TX_ID   = 4'd0;
  localparam logic [3:0] A_TX_DLC  = 4'd1;
  localparam logic [3:0] A_TX_DLO  = 4'd2;
  localparam logic [3:0] A_TX_DHI  = 4'd3;
  localparam logic [3:0] A_RX_ID   = 4'd4;
  localparam logic [3:0] A_RX_DLC  = 4'd5;
  localparam logic [3:0] A_RX_DLO  = 4'd6;
  localparam logic [3:0] A_RX_DHI  = 4'd7;
  localparam logic [3:0] A_TX_CTL  = 4'd8;
  localparam logic [3:0] A_TX_PTR  = 4'd9;
  localparam logic [3:0] A_RX_CTL  = 4'd10;
  localparam logic [3:0] A_RX_PTR  = 4'd11;
  localparam logic [3:0] A_INT_STS = 4'd12;
  localparam logic [3:0] A_INT_EN  = 4'd13;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [DLC_W-1:0]  dlc;
    logic [DATA_W-1:0] data;
  } cfw_frame_t;

  localparam int FRAME_W = $bits(cfw_frame_t);

  function automatic cfw_frame_t strip_remote(input cfw_frame_t f);
    cfw_frame_t r;
    r = f;
    if (f.id[RTR_BIT]) r.data = '0;
    return r;
  endfunction
endpackage

// File: rtl/cfw_msg_queue.sv
module cfw_msg_queue #(
  parameter int DEPTH = 4,
  parameter int W     = 100,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [W-1:0]     push_data_i,
  input  logic             pop_i,
  output logic [W-1:0]     head_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [W-1:0]     slot_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign count_o = cnt_q;
  assign head_o  = empty_o ? '0 : slot_q[rd_ptr_q];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) slot_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= bump(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= bump(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= CNT_W'(DEPTH));
  assert_full_refuse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full_o && !pop_i) |=> (count_o == $past(count_o)));
  assert_pop_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !empty_o && !push_i) |=> (count_o == $past(count_o) - CNT_W'(1)));
endmodule

// File: rtl/cfw_tx_stage.sv
module cfw_tx_stage
  import cfw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en_i,
  input  logic [3:0]  addr_i,
  input  logic [31:0] wdata_i,
  output cfw_frame_t  frame_o
);
  cfw_frame_t stage_q;
  assign frame_o = stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        A_TX_ID:  stage_q.id          <= wdata_i;
        A_TX_DLC: stage_q.dlc         <= wdata_i[DLC_W-1:0];
        A_TX_DLO: stage_q.data[31:0]  <= wdata_i;
        A_TX_DHI: stage_q.data[63:32] <= wdata_i;
        default:  stage_q             <= stage_q;
      endcase
    end
  end
endmodule

// File: rtl/cfw_irq_flags.sv
module cfw_irq_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_evt_i,
  input  logic       rx_evt_i,
  input  logic       sts_wr_i,
  input  logic       en_wr_i,
  input  logic [1:0] bits_i,
  output logic [1:0] sts_o,
  output logic [1:0] en_o,
  output logic       irq_o
);
  logic [1:0] sts_q, en_q, keep;

  assign keep  = sts_wr_i ? bits_i : 2'b11;
  assign sts_o = sts_q;
  assign en_o  = en_q;
  assign irq_o = |(sts_q & en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= (sts_q & keep) | {rx_evt_i, tx_evt_i};
      if (en_wr_i) en_q <= bits_i;
    end
  end

  assert_tx_flag_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_evt_i |=> sts_o[0]);
  assert_rx_flag_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_evt_i |=> sts_o[1]);
  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sts_wr_i && sts_o[0]) |=> sts_o[0]);
  assert_irq_needs_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (en_o != 2'b00) && (sts_o != 2'b00));
endmodule

// File: rtl/can_fifo_window.sv
module can_fifo_window
  import cfw_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_wr_en,
  input  logic [3:0]  cpu_addr,
  input  logic [31:0] cpu_wdata,
  output logic [31:0] cpu_rdata,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [31:0] tx_id,
  output logic [3:0]  tx_dlc,
  output logic [63:0] tx_data,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [31:0] rx_id,
  input  logic [3:0]  rx_dlc,
  input  logic [63:0] rx_data,
  output logic        rx_overrun,
  output logic        irq
);
  logic tx_en_q, rx_en_q;
  cfw_frame_t stage, tx_head, rx_head, rx_in;
  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic tx_commit, tx_pop, rx_take, rx_release;
  logic [1:0] sts, ien;

  assign tx_commit  = cpu_wr_en && (cpu_addr == A_TX_PTR) &&
                      (cpu_wdata[7:0] == PTR_MAGIC) && tx_en_q;
  assign rx_release = cpu_wr_en && (cpu_addr == A_RX_PTR) &&
                      (cpu_wdata[7:0] == PTR_MAGIC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en_q <= 1'b0;
      rx_en_q <= 1'b0;
    end else if (cpu_wr_en) begin
      if (cpu_addr == A_TX_CTL) tx_en_q <= cpu_wdata[0];
      if (cpu_addr == A_RX_CTL) rx_en_q <= cpu_wdata[0];
    end
  end

  cfw_tx_stage u_stage (
    .clk(clk), .rst_n(rst_n), .wr_en_i(cpu_wr_en),
    .addr_i(cpu_addr), .wdata_i(cpu_wdata), .frame_o(stage)
  );

  cfw_msg_queue #(.DEPTH(DEPTH), .W(FRAME_W)) u_txq (
    .clk(clk), .rst_n(rst_n), .push_i(tx_commit),
    .push_data_i(strip_remote(stage)), .pop_i(tx_pop),
    .head_o(tx_head), .count_o(tx_cnt), .full_o(tx_full), .empty_o(tx_empty)
  );

  assign tx_valid = tx_en_q && !tx_empty;
  assign tx_pop   = tx_valid && tx_ready;
  assign tx_id    = tx_head.id;
  assign tx_dlc   = tx_head.dlc;
  assign tx_data  = tx_head.data;

  assign rx_in.id   = rx_id;
  assign rx_in.dlc  = rx_dlc;
  assign rx_in.data = rx_data;
  assign rx_ready   = rx_en_q;
  assign rx_take    = rx_valid && rx_en_q;
  assign rx_overrun = rx_take && rx_full;

  cfw_msg_queue #(.DEPTH(DEPTH), .W(FRAME_W)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push_i(rx_take),
    .push_data_i(strip_remote(rx_in)), .pop_i(rx_release),
    .head_o(rx_head), .count_o(rx_cnt), .full_o(rx_full), .empty_o(rx_empty)
  );

  cfw_irq_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .tx_evt_i(tx_pop), .rx_evt_i(rx_take && !rx_full),
    .sts_wr_i(cpu_wr_en && (cpu_addr == A_INT_STS)),
    .en_wr_i(cpu_wr_en && (cpu_addr == A_INT_EN)),
    .bits_i({cpu_wdata[RXF_BIT], cpu_wdata[TXF_BIT]}),
    .sts_o(sts), .en_o(ien), .irq_o(irq)
  );

  always_comb begin
    cpu_rdata = '0;
    case (cpu_addr)
      A_TX_ID:   cpu_rdata = stage.id;
      A_TX_DLC:  cpu_rdata[DLC_W-1:0] = stage.dlc;
      A_TX_DLO:  cpu_rdata = stage.data[31:0];
      A_TX_DHI:  cpu_rdata = stage.data[63:32];
      A_RX_ID:   cpu_rdata = rx_head.id;
      A_RX_DLC:  cpu_rdata[DLC_W-1:0] = rx_head.dlc;
      A_RX_DLO:  cpu_rdata = rx_head.data[31:0];
      A_RX_DHI:  cpu_rdata = rx_head.data[63:32];
      A_TX_CTL: begin
        cpu_rdata[0]       = tx_en_q;
        cpu_rdata[CNT_W:1] = tx_cnt;
      end
      A_RX_CTL: begin
        cpu_rdata[0] = rx_en_q;
        cpu_rdata[7] = rx_empty;
      end
      A_INT_STS: begin
        cpu_rdata[TXF_BIT] = sts[0];
        cpu_rdata[RXF_BIT] = sts[1];
      end
      A_INT_EN: begin
        cpu_rdata[TXF_BIT] = ien[0];
        cpu_rdata[RXF_BIT] = ien[1];
      end
      default:   cpu_rdata = '0;
    endcase
  end

  assert_rx_drop_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_overrun && !rx_release) |=> (rx_cnt == $past(rx_cnt)));
  assert_tx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !(cpu_wr_en && cpu_addr == A_TX_CTL))
      |=> (tx_valid && $stable(tx_id) && $stable(tx_data) && $stable(tx_dlc)));
  assert_remote_no_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_id[RTR_BIT]) |-> (tx_data == '0));
  assert_disabled_refuse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en_q && !tx_pop) |=> (tx_cnt == $past(tx_cnt)));
endmodule

// File: tb/can_fifo_window_test.sv
`timescale 1ns/1ps
module can_fifo_window_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_wr_en = 1'b0;
  logic [3:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic tx_valid, tx_ready = 1'b0;
  logic [31:0] tx_id;
  logic [3:0] tx_dlc;
  logic [63:0] tx_data;
  logic rx_valid = 1'b0, rx_ready;
  logic [31:0] rx_id = '0;
  logic [3:0] rx_dlc = '0;
  logic [63:0] rx_data = '0;
  logic rx_overrun, irq;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  can_fifo_window uut (.*);

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    cpu_wr_en = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    cpu_addr = a;
    #0.5;
    d = cpu_rdata;
  endtask

  task automatic stage(logic [31:0] id, logic [3:0] dlc, logic [63:0] data);
    wr(4'd0, id); wr(4'd1, {28'd0, dlc});
    wr(4'd2, data[31:0]); wr(4'd3, data[63:32]);
  endtask

  task automatic pop_one();
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
  endtask

  task automatic push(logic [31:0] id, logic [3:0] dlc, logic [63:0] data, output logic ovr);
    @(negedge clk);
    rx_valid = 1'b1; rx_id = id; rx_dlc = dlc; rx_data = data;
    #0.5 ovr = rx_overrun;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(4'd8, v);  chk("R1", "tx ctl", v, 0);
    rd(4'd10, v); chk("R1", "rx ctl", v, 32'h80);
    rd(4'd12, v); chk("R1", "status", v, 0);
    chk("R1", "irq/txv/rxr/ovr", {irq, tx_valid, rx_ready, rx_overrun}, 0);
  endtask

  task automatic t_tx_basic();
    logic [31:0] v;
    wr(4'd8, 1);
    stage(32'h048C0000, 4'd8, 64'h8877665544332211);
    wr(4'd9, 32'h7F);
    rd(4'd8, v); chk("R2", "non-magic commit ignored", v, 32'h1);
    wr(4'd9, 32'hFF);
    rd(4'd8, v); chk("R3", "unsent count 1", v, 32'h3);
    chk("R2", "tx id", tx_id, 32'h048C0000);
    chk("R2", "tx dlc", tx_dlc, 8);
    chk("R2", "tx data", tx_data, 64'h8877665544332211);
    repeat (3) @(negedge clk);
    chk("R6", "held valid+id", {tx_valid, tx_id}, {1'b1, 32'h048C0000});
    pop_one();
    chk("R6", "valid after pop", tx_valid, 0);
    rd(4'd8, v); chk("R3", "count after pop", v, 32'h1);
    rd(4'd12, v); chk("R10", "tx flag", v, 32'h08);
    chk("R11", "irq masked", irq, 0);
    wr(4'd13, 32'h08);
    chk("R11", "irq enabled", irq, 1);
    wr(4'd12, 32'hFFFFFFF7);
    chk("R11", "irq after clear", irq, 0);
    rd(4'd12, v); chk("R10", "tx flag cleared", v, 0);
    wr(4'd13, 0);
  endtask

  task automatic t_tx_full();
    logic [31:0] v;
    for (int i = 1; i <= 5; i++) begin
      stage(32'h80000000 | i, 4'(i), 64'(i));
      wr(4'd9, 32'hFF);
    end
    rd(4'd8, v); chk("R4", "full count 4", v, 32'h9);
    for (int i = 1; i <= 4; i++) begin
      chk("R3", "order id", tx_id, 32'h80000000 | i);
      pop_one();
    end
    chk("R3", "drained", tx_valid, 0);
    wr(4'd8, 0);
    wr(4'd9, 32'hFF);
    wr(4'd8, 1);
    rd(4'd8, v); chk("R4", "disabled commit ignored", v, 32'h1);
    chk("R4", "no frame after disabled commit", tx_valid, 0);
  endtask

  task automatic t_remote();
    stage(32'h40000000 | (32'h55 << 18), 4'd6, 64'hDEADBEEFCAFEF00D);
    wr(4'd9, 32'hFF);
    chk("R5", "remote tx data zero", tx_data, 0);
    chk("R5", "remote tx dlc kept", tx_dlc, 6);
    pop_one();
  endtask

  task automatic t_rx();
    logic [31:0] v;
    logic o;
    wr(4'd10, 1);
    chk("R7", "rx_ready on enable", rx_ready, 1);
    rd(4'd10, v); chk("R7", "rx ctl empty", v, 32'h81);
    push(32'h0AB << 18, 4'd2, 64'hBEEF, o);
    chk("R9", "no overrun", o, 0);
    push(32'h40000123, 4'd3, 64'h1234, o);
    rd(4'd10, v); chk("R7", "rx ctl nonempty", v, 32'h01);
    rd(4'd4, v); chk("R7", "window id A", v, 32'h0AB << 18);
    rd(4'd5, v); chk("R7", "window dlc A", v, 2);
    rd(4'd6, v); chk("R7", "window data A", v, 32'hBEEF);
    wr(4'd11, 32'hFF);
    rd(4'd4, v); chk("R8", "window id B", v, 32'h40000123);
    rd(4'd6, v); chk("R5", "remote rx data zero", v, 0);
    wr(4'd11, 32'hFF);
    rd(4'd10, v); chk("R8", "empty after releases", v, 32'h81);
    wr(4'd11, 32'hFF);
    push(32'h0C, 4'd1, 64'hC, o);
    rd(4'd4, v); chk("R8", "empty release ignored", v, 32'h0C);
    wr(4'd11, 32'h12);
    rd(4'd4, v); chk("R8", "non-magic release ignored", v, 32'h0C);
    for (int i = 13; i <= 15; i++) push(32'(i), 4'd1, 64'(i), o);
    push(32'h77, 4'd1, 64'h77, o);
    chk("R9", "overrun on full", o, 1);
    for (int i = 12; i <= 15; i++) begin
      rd(4'd4, v); chk("R9", "kept frames order", v, 32'(i));
      wr(4'd11, 32'hFF);
    end
    rd(4'd10, v); chk("R9", "dropped frame absent", v, 32'h81);
  endtask

  task automatic t_flags();
    logic [31:0] v;
    logic o;
    rd(4'd12, v); chk("R10", "both flags", v, 32'h18);
    wr(4'd12, 32'hFFFFFFEF);
    rd(4'd12, v); chk("R10", "one keeps flag", v, 32'h08);
    wr(4'd13, 32'h10);
    chk("R11", "rx flag clear no irq", irq, 0);
    push(32'h5, 4'd0, 64'h0, o);
    chk("R11", "rx irq", irq, 1);
    wr(4'd12, 32'h0);
    rd(4'd12, v); chk("R10", "all cleared", v, 0);
    chk("R11", "irq low", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tx_basic();
    t_tx_full();
    t_remote();
    t_rx();
    t_flags();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule